// File: doc/BRIEF.md
# Configurable PLD Macrocell Register

This block is the storage and output stage of one macrocell in a programmable logic array. It takes the summed product terms for its cell and, depending on configuration, passes them straight through, holds them in a level-sensitive latch, or stores them in a flip-flop that acts as a D, T, JK or SR type. The result goes to the pin through a programmable inverter and is also returned to the array as feedback at all times.

Each cell chooses between two timing schemes. In synchronous mode it shares one of the block's clocks and the block's two initialisation terms with its neighbours. In asynchronous mode it has its own product-term clock with a selectable edge and a single private init term. The block clocks and the product-term clock arrive as level signals and are edge-detected on the fast system clock `clk_i`. A test port can preload the storage from an external value, or drive the stored value out with output enable forced on.

Top module: `mc_cell`

## Requirements
- R1: While `rst_ni` is low and after its release, the storage holds 0, so in a storing mode with no init active `pin_o` equals `cfg_inv_i`.
- R2: With `cfg_omode_i` = 0 (combinational), `fb_o` equals `sum_i` and `pin_o` equals `sum_i ^ cfg_inv_i` in the same cycle.
- R3: With `cfg_omode_i` = 2 or 3 (registered), the storage changes only on a clock edge and then takes the value given by `cfg_ftype_i`: 0 = D (next = `sum_i`), 1 = T (toggle when `sum_i`), 2 = JK (J = `sum_i`, K = `aux_i`), 3 = SR (S = `sum_i`, R = `aux_i`, R wins).
- R4: In synchronous mode (`cfg_async_i` = 0) the clock is the rising edge of `blk_clk_i[cfg_csel_i]`; edges on other block clocks have no effect.
- R5: In asynchronous mode the clock is `pt_clk_i`, on its rising edge when `cfg_fall_i` = 0 and its falling edge when `cfg_fall_i` = 1.
- R6: With `cfg_omode_i` = 1 (latch), the output follows `sum_i` in the same cycle while the selected gate is open (selected block clock high, or `pt_clk_i` equal to `!cfg_fall_i` in asynchronous mode), and holds once it closes.
- R7: In synchronous mode `blk_rst_i` clears and `blk_pre_i` sets the storage; with `cfg_swap_i` = 1 the two roles are exchanged.
- R8: In asynchronous mode `pt_init_i` sets the storage when `cfg_apre_i` = 1 and clears it when `cfg_apre_i` = 0; block init terms are ignored.
- R9: When a clear and a set are requested together, the clear wins.
- R10: An active init forces the output in the same cycle; after release, the first selected clock edge leaves the storage unchanged and loading resumes on the next edge.
- R11: With `tmode_i` = 1 (preload), the storage takes `preload_i` on each system clock, ahead of any init.
- R12: With `tmode_i` = 2 (observe), `oe_o` is 1 regardless of `oe_i`, `pin_o` shows the stored value through the inverter, and a combinational cell behaves as registered with `sum_i` and `aux_i` taken as 0.
- R13: `fb_o` is independent of `oe_i`; with `tmode_i` = 0 or 3, `oe_o` equals `oe_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low power-up reset |
| blk_clk_i | input | NCLK | Shared block clock levels |
| pt_clk_i | input | 1 | Private product-term clock level |
| sum_i | input | 1 | Main product-term sum (D, T, J, S, latch data) |
| aux_i | input | 1 | Second term (K, R) |
| blk_pre_i | input | 1 | Shared block preset term |
| blk_rst_i | input | 1 | Shared block reset term |
| pt_init_i | input | 1 | Private init term (asynchronous mode) |
| cfg_omode_i | input | 2 | 0 comb, 1 latch, 2/3 registered |
| cfg_ftype_i | input | 2 | 0 D, 1 T, 2 JK, 3 SR |
| cfg_inv_i | input | 1 | Output inversion |
| cfg_async_i | input | 1 | 1 selects asynchronous mode |
| cfg_csel_i | input | CSW | Block clock index |
| cfg_fall_i | input | 1 | Product-term clock falling edge |
| cfg_swap_i | input | 1 | Exchange block preset and reset |
| cfg_apre_i | input | 1 | Private init term presets (1) or resets (0) |
| tmode_i | input | 2 | 0/3 normal, 1 preload, 2 observe |
| preload_i | input | 1 | Preload data |
| oe_i | input | 1 | Output enable term |
| pin_o | output | 1 | Polarity-adjusted cell output |
| oe_o | output | 1 | Output enable to the pin buffer |
| fb_o | output | 1 | Feedback to the array |

## Verification
The bench walks every flip-flop type through each row of its truth table, including JK toggle and SR with both inputs set, where a wrong priority would leave the cell set. It aims edges at unselected block clocks and at the wrong product-term edge, which a bad selector would turn into a load. It checks the cycle after init release, where a design without release synchronisation would load on the first edge, and the swap and clear-versus-set cases, where a mix-up gives the opposite level. Observe on a combinational cell must show stored data and then clear it on an edge, which a design that kept the cell combinational would not.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {OM_COMB = 2'd0, OM_LATCH = 2'd1, OM_REG = 2'd2, OM_REG2 = 2'd3} omode_e;
  typedef enum logic [1:0] {FT_D = 2'd0, FT_T = 2'd1, FT_JK = 2'd2, FT_SR = 2'd3} ftype_e;
  typedef enum logic [1:0] {TM_RUN = 2'd0, TM_LOAD = 2'd1, TM_OBS = 2'd2, TM_RUN2 = 2'd3} tmode_e;
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int NCLK = 4,
  parameter int CSW  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLK-1:0] blk_clk_i,
  input  logic            pt_clk_i,
  input  logic            async_i,
  input  logic [CSW-1:0]  csel_i,
  input  logic            fall_i,
  output logic            edge_o,
  output logic            gate_o
);
  localparam int NSRC = NCLK + 1;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] raw_q;
  logic            sel_now;
  logic            sel_prev;

  assign raw = {pt_clk_i, blk_clk_i};

  // one history bit per clock source, so a config change never fakes an edge
  for (genvar g = 0; g < NSRC; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_q[g] <= 1'b0;
      else         raw_q[g] <= raw[g];
    end
  end

  always_comb begin
    if (async_i) begin
      sel_now  = raw[NCLK]   ^ fall_i;
      sel_prev = raw_q[NCLK] ^ fall_i;
    end else begin
      sel_now  = raw[csel_i];
      sel_prev = raw_q[csel_i];
    end
  end

  assign edge_o = sel_now & ~sel_prev;
  assign gate_o = sel_now;
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_pkg::*;
(
  input  ftype_e ftype_i,
  input  logic   q_i,
  input  logic   a_i,
  input  logic   b_i,
  output logic   d_o
);
  always_comb begin
    unique case (ftype_i)
      FT_D:  d_o = a_i;
      FT_T:  d_o = q_i ^ a_i;
      FT_JK: d_o = (a_i & ~q_i) | (~b_i & q_i);
      FT_SR: d_o = ~b_i & (a_i | q_i);
      default: d_o = q_i;
    endcase
  end
endmodule

// File: rtl/mc_init.sv
module mc_init (
  input  logic async_i,
  input  logic swap_i,
  input  logic apre_i,
  input  logic pt_init_i,
  input  logic blk_pre_i,
  input  logic blk_rst_i,
  output logic clr_o,
  output logic set_o
);
  logic want_clr;
  logic want_set;

  always_comb begin
    if (async_i) begin
      want_clr = pt_init_i & ~apre_i;
      want_set = pt_init_i &  apre_i;
    end else if (swap_i) begin
      want_clr = blk_pre_i;
      want_set = blk_rst_i;
    end else begin
      want_clr = blk_rst_i;
      want_set = blk_pre_i;
    end
  end

  assign clr_o = want_clr;
  assign set_o = want_set & ~want_clr;
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
#(
  parameter int NCLK = 4,
  localparam int CSW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCLK-1:0] blk_clk_i,
  input  logic            pt_clk_i,
  input  logic            sum_i,
  input  logic            aux_i,
  input  logic            blk_pre_i,
  input  logic            blk_rst_i,
  input  logic            pt_init_i,
  input  logic [1:0]      cfg_omode_i,
  input  logic [1:0]      cfg_ftype_i,
  input  logic            cfg_inv_i,
  input  logic            cfg_async_i,
  input  logic [CSW-1:0]  cfg_csel_i,
  input  logic            cfg_fall_i,
  input  logic            cfg_swap_i,
  input  logic            cfg_apre_i,
  input  logic [1:0]      tmode_i,
  input  logic            preload_i,
  input  logic            oe_i,
  output logic            pin_o,
  output logic            oe_o,
  output logic            fb_o
);
  omode_e om_eff;
  tmode_e tm;
  logic   obs, pload;
  logic   sum_eff, aux_eff;
  logic   is_comb, is_latch;
  logic   fn_edge, gate;
  logic   init_clr, init_set, init_act;
  logic   next_d;
  logic   stor_q, hold_q;
  logic   latch_val, cell_val;

  assign tm       = tmode_e'(tmode_i);
  assign obs      = (tm == TM_OBS);
  assign pload    = (tm == TM_LOAD);
  // observe forces a storing cell with all terms low
  assign om_eff   = obs ? OM_REG : omode_e'(cfg_omode_i);
  assign sum_eff  = sum_i & ~obs;
  assign aux_eff  = aux_i & ~obs;
  assign is_comb  = (om_eff == OM_COMB);
  assign is_latch = (om_eff == OM_LATCH);

  mc_clk_sel #(.NCLK(NCLK), .CSW(CSW)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blk_clk_i(blk_clk_i),
    .pt_clk_i (pt_clk_i),
    .async_i  (cfg_async_i),
    .csel_i   (cfg_csel_i),
    .fall_i   (cfg_fall_i),
    .edge_o   (fn_edge),
    .gate_o   (gate)
  );

  mc_init u_init (
    .async_i  (cfg_async_i),
    .swap_i   (cfg_swap_i),
    .apre_i   (cfg_apre_i),
    .pt_init_i(pt_init_i),
    .blk_pre_i(blk_pre_i),
    .blk_rst_i(blk_rst_i),
    .clr_o    (init_clr),
    .set_o    (init_set)
  );

  assign init_act = init_clr | init_set;

  mc_next_state u_ns (
    .ftype_i(ftype_e'(cfg_ftype_i)),
    .q_i    (stor_q),
    .a_i    (sum_eff),
    .b_i    (aux_eff),
    .d_o    (next_d)
  );

  assign latch_val = (gate && !hold_q) ? sum_eff : stor_q;

  // hold_q: init released but the synchronising edge not yet seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stor_q <= 1'b0;
      hold_q <= 1'b0;
    end else if (pload) begin
      stor_q <= preload_i;
      hold_q <= 1'b0;
    end else if (init_act) begin
      stor_q <= init_set;
      hold_q <= 1'b1;
    end else if (hold_q) begin
      if (fn_edge) hold_q <= 1'b0;
    end else if (is_latch) begin
      stor_q <= latch_val;
    end else if (!is_comb && fn_edge) begin
      stor_q <= next_d;
    end
  end

  always_comb begin
    if (is_comb)       cell_val = sum_eff;
    else if (init_act) cell_val = init_set;
    else if (is_latch) cell_val = latch_val;
    else               cell_val = stor_q;
  end

  assign fb_o  = cell_val;
  assign pin_o = cell_val ^ cfg_inv_i;
  assign oe_o  = obs | oe_i;
endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk #(
  parameter int NCLK = 4,
  parameter int CSW  = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NCLK-1:0] blk_clk_i,
  input logic            pt_clk_i,
  input logic            blk_pre_i,
  input logic            blk_rst_i,
  input logic            pt_init_i,
  input logic [1:0]      cfg_omode_i,
  input logic [1:0]      cfg_ftype_i,
  input logic            cfg_inv_i,
  input logic            cfg_async_i,
  input logic [CSW-1:0]  cfg_csel_i,
  input logic            cfg_fall_i,
  input logic            cfg_swap_i,
  input logic [1:0]      tmode_i,
  input logic            preload_i,
  input logic            pin_o,
  input logic            oe_o,
  input logic            fb_o
);
  logic [1:0] age_q;
  logic       no_init;
  logic       quiet;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age_q <= 2'd0;
    else if (!age_q[1]) age_q <= age_q + 2'd1;
  end

  assign no_init = !blk_pre_i && !blk_rst_i && !pt_init_i;
  assign quiet   = cfg_omode_i[1] && (tmode_i == 2'd0) && no_init;

  a_r12_observe_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmode_i == 2'd2) |-> oe_o);

  a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_async_i && !cfg_swap_i && blk_pre_i && blk_rst_i &&
     tmode_i != 2'd1 && cfg_omode_i != 2'd0) |-> (pin_o == cfg_inv_i));

  a_r11_preload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && $past(tmode_i == 2'd1) && cfg_omode_i[1] && no_init)
      |-> (fb_o == $past(preload_i)));

  a_r3_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q[1] && quiet && $past(quiet) &&
     $past($stable(blk_clk_i) && $stable(pt_clk_i) && $stable(cfg_async_i) &&
           $stable(cfg_csel_i) && $stable(cfg_fall_i) && $stable(cfg_ftype_i) &&
           $stable(cfg_omode_i)))
      |-> (fb_o == $past(fb_o)));
endmodule

bind mc_cell mc_cell_chk #(.NCLK(NCLK), .CSW(CSW)) u_chk (.*);

// File: tb/sim_mc_cell.sv
`timescale 1ns/1ps
module sim_mc_cell;
  localparam int NCLK = 4;
  localparam int CSW  = 2;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [NCLK-1:0] blk_clk_i;
  logic            pt_clk_i, sum_i, aux_i, blk_pre_i, blk_rst_i, pt_init_i;
  logic [1:0]      cfg_omode_i, cfg_ftype_i, tmode_i;
  logic            cfg_inv_i, cfg_async_i, cfg_fall_i, cfg_swap_i, cfg_apre_i;
  logic [CSW-1:0]  cfg_csel_i;
  logic            preload_i, oe_i;
  logic            pin_o, oe_o, fb_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  mc_cell #(.NCLK(NCLK)) u0 (.*);

  // {ftype[1:0], pre, a, b, expected}
  localparam logic [5:0] VEC [14] = '{
    {2'd0, 1'b0, 1'b1, 1'b0, 1'b1}, {2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd1, 1'b0, 1'b1, 1'b0, 1'b1}, {2'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b1}, {2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b1, 1'b0}, {2'd2, 1'b0, 1'b1, 1'b1, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b1}, {2'd3, 1'b1, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0}, {2'd3, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic preload(input logic v);
    tmode_i = 2'd1; preload_i = v;
    @(negedge clk_i);
    tmode_i = 2'd0;
  endtask

  task automatic blk_pulse(input int idx);
    blk_clk_i[idx] = 1'b1;
    @(negedge clk_i);
    blk_clk_i[idx] = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic pt_toggle(input logic v);
    pt_clk_i = v;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; blk_clk_i = '0; pt_clk_i = 1'b0; sum_i = 1'b0; aux_i = 1'b0;
    blk_pre_i = 1'b0; blk_rst_i = 1'b0; pt_init_i = 1'b0;
    cfg_omode_i = 2'd2; cfg_ftype_i = 2'd0; cfg_inv_i = 1'b1; cfg_async_i = 1'b0;
    cfg_csel_i = '0; cfg_fall_i = 1'b0; cfg_swap_i = 1'b0; cfg_apre_i = 1'b0;
    tmode_i = 2'd0; preload_i = 1'b0; oe_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 during reset", pin_o, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", pin_o, 1'b1);
    cfg_inv_i = 1'b0;

    // R3 flip-flop truth tables on block clock 1
    cfg_csel_i = 2'd1;
    foreach (VEC[i]) begin
      cfg_ftype_i = VEC[i][5:4];
      preload(VEC[i][3]);
      check("R11 preload", fb_o, VEC[i][3]);
      sum_i = VEC[i][2]; aux_i = VEC[i][1];
      blk_pulse(1);
      check($sformatf("R3 vector %0d", i), fb_o, VEC[i][0]);
    end

    // R4 unselected clocks ignored
    cfg_ftype_i = 2'd0; cfg_csel_i = 2'd2; sum_i = 1'b1;
    preload(1'b0);
    blk_pulse(0); blk_pulse(1); blk_pulse(3);
    check("R4 other clocks ignored", fb_o, 1'b0);
    blk_pulse(2);
    check("R4 selected clock loads", fb_o, 1'b1);

    // R5 async falling edge
    cfg_async_i = 1'b1; cfg_fall_i = 1'b1;
    preload(1'b0);
    pt_toggle(1'b1);
    check("R5 rising ignored", fb_o, 1'b0);
    pt_toggle(1'b0);
    check("R5 falling loads", fb_o, 1'b1);
    cfg_fall_i = 1'b0; sum_i = 1'b0;
    pt_toggle(1'b1);
    check("R5 rising loads", fb_o, 1'b0);
    pt_toggle(1'b0);

    // R8 private init term
    sum_i = 1'b0; cfg_apre_i = 1'b1; blk_rst_i = 1'b1; pt_init_i = 1'b1;
    #1 check("R8 preset, block reset ignored", pin_o, 1'b1);
    cfg_apre_i = 1'b0;
    #1 check("R8 reset", pin_o, 1'b0);
    pt_init_i = 1'b0; blk_rst_i = 1'b0;
    @(negedge clk_i);
    cfg_async_i = 1'b0;

    // R7 swap, R9 clear wins
    cfg_csel_i = 2'd0; preload(1'b0);
    cfg_swap_i = 1'b1; blk_rst_i = 1'b1;
    #1 check("R7 swapped reset presets", pin_o, 1'b1);
    blk_rst_i = 1'b0; cfg_swap_i = 1'b0; blk_pre_i = 1'b1;
    #1 check("R7 preset", pin_o, 1'b1);
    blk_rst_i = 1'b1;
    #1 check("R9 clear wins", pin_o, 1'b0);
    @(negedge clk_i);

    // R10 release synchronised to first edge
    blk_pre_i = 1'b0; blk_rst_i = 1'b1; sum_i = 1'b1;
    #1 check("R10 immediate clear", fb_o, 1'b0);
    @(negedge clk_i);
    blk_rst_i = 1'b0;
    blk_pulse(0);
    check("R10 first edge after release ignored", fb_o, 1'b0);
    blk_pulse(0);
    check("R10 second edge loads", fb_o, 1'b1);

    // R6 latch
    cfg_omode_i = 2'd1; preload(1'b0);
    sum_i = 1'b1; blk_clk_i[0] = 1'b1;
    #1 check("R6 transparent", pin_o, 1'b1);
    @(negedge clk_i);
    blk_clk_i[0] = 1'b0; sum_i = 1'b0;
    #1 check("R6 holds when closed", pin_o, 1'b1);
    @(negedge clk_i);

    // R2 combinational with inversion, R13 feedback vs oe
    cfg_omode_i = 2'd0; cfg_inv_i = 1'b1; oe_i = 1'b0; sum_i = 1'b0;
    #1 check("R2 comb inverted low", pin_o, 1'b1);
    sum_i = 1'b1;
    #1 check("R2 comb inverted high", pin_o, 1'b0);
    check("R13 feedback with oe low", fb_o, 1'b1);
    check("R13 oe passes through", oe_o, 1'b0);

    // R12 observe on a combinational cell
    preload(1'b1);
    tmode_i = 2'd2;
    #1 check("R12 oe forced", oe_o, 1'b1);
    check("R12 stored value shown", pin_o, 1'b0);
    blk_clk_i[0] = 1'b1;
    @(negedge clk_i);
    blk_clk_i[0] = 1'b0;
    @(negedge clk_i);
    check("R12 zero terms loaded", pin_o, 1'b1);
    tmode_i = 2'd0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule